// File: doc/BRIEF.md
# Dual-Path Overrange Detector

This block raises a single overrange status bit for a sigma-delta converter front end. It watches two sources at once. The first is the signed output of the first decimation stage, sampled on a valid strobe, whose magnitude is compared against a programmable 16-bit threshold. That compare happens before any gain or offset correction, so the warning arrives with little delay. The second is a per-modulator-clock full-scale indication. A saturating counter on that input trips when full-scale codes persist.

The threshold is a fraction of full scale. A threshold value `T` stands for `T / 2^16` of full scale, and a sample `x` of `SAMP_W` bits stands for `|x| / 2^(SAMP_W-1)`. The flag is registered. A trip from either path sets it on the next clock edge. It drops only at a first-stage valid that closes a whole sample period in which neither path tripped.

Top module: `ovr_detect`

## Requirements
- R1: After reset the threshold reads back as 0xCCCC (80 % of full scale) and the flag is 0.
- R2: A cycle with `cfg_we` high loads `cfg_wdata` into the threshold, and the new value is visible on `thr_rdata` at the next edge.
- R3: A cycle with `stage_valid` high and `|stage_data| * 2^16 > thr * 2^(SAMP_W-1)` sets `ovr_flag` at the next edge.
- R4: A sample whose magnitude is exactly equal to the threshold fraction does not trip the compare path.
- R5: Negative samples are judged by magnitude, so -x trips exactly when +x would.
- R6: With `mod_tick` high and `mod_full` high, the fifth consecutive full-scale tick sets the flag at the next edge. Four such ticks do not set it.
- R7: A tick with `mod_full` low restarts the run count. Cycles with `mod_tick` low neither advance nor break a run.
- R8: At a `stage_valid` cycle, the flag clears if the current sample does not trip and no run trip occurred since the previous valid.
- R9: The flag holds between valid strobes. A run trip inside a period keeps it set through the valid that closes that period.
- R10: The run counter saturates. A long full-scale run keeps tripping, and after one non-full tick five new full-scale ticks are again needed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Threshold write strobe |
| cfg_wdata | input | 16 | Threshold write value (fraction of full scale) |
| thr_rdata | output | 16 | Current threshold |
| stage_valid | input | 1 | First-stage sample strobe |
| stage_data | input | SAMP_W (24) | Signed first-stage sample |
| mod_tick | input | 1 | Modulator sample enable |
| mod_full | input | 1 | Modulator code is at or beyond full scale |
| ovr_flag | output | 1 | Overrange status bit |

## Verification
A corrupted threshold shows directly on `thr_rdata` one edge after the write. It also moves the trip point that the bench probes at the exact boundary sample. A run counter that is off by one or fails to clear gives a flag one tick early or late, visible within five modulator ticks. A window bit that is stuck shows up as a flag that clears one valid period too early or too late. Random traffic compares the flag against an independent model on every cycle, so any such fault appears within a few sample periods.

// File: rtl/ovr_pkg.sv
package ovr_pkg;
   // counter width able to hold the saturation value RUN_LIMIT+1
   function automatic int run_cnt_w(input int limit);
      return (limit < 1) ? 1 : $clog2(limit + 2);
   endfunction
endpackage

// File: rtl/ovr_thr_reg.sv
module ovr_thr_reg #(
   parameter int          THR_W   = 16,
   parameter logic [15:0] RST_VAL = 16'hCCCC
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             we,
   input  logic [THR_W-1:0] wdata,
   output logic [THR_W-1:0] q
);
   always_ff @(posedge clk) begin
      if (!rst_n)  q <= THR_W'(RST_VAL);
      else if (we) q <= wdata;
   end
endmodule

// File: rtl/ovr_mag_cmp.sv
module ovr_mag_cmp #(
   parameter int SAMP_W = 24,
   parameter int THR_W  = 16
) (
   input  logic signed [SAMP_W-1:0] sample,
   input  logic        [THR_W-1:0]  thr,
   output logic                     over
);
   localparam int CMP_W = SAMP_W + THR_W;

   logic [SAMP_W-1:0] mag;
   logic [CMP_W-1:0]  lhs, rhs;

   // the most negative code maps to 2^(SAMP_W-1), which still fits unsigned
   always_comb mag = sample[SAMP_W-1] ? (~sample + 1'b1) : sample;

   always_comb begin
      lhs  = {mag, {THR_W{1'b0}}};
      rhs  = CMP_W'(thr) << (SAMP_W - 1);
      over = lhs > rhs;
   end
endmodule

// File: rtl/ovr_run_cnt.sv
module ovr_run_cnt #(
   parameter int RUN_LIMIT = 4,
   parameter int CNT_W     = ovr_pkg::run_cnt_w(RUN_LIMIT)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             full,
   output logic [CNT_W-1:0] cnt,
   output logic             trip
);
   generate
      if (RUN_LIMIT == 0) begin : g_direct
         // any full-scale tick trips at once; no history kept
         assign cnt  = '0;
         assign trip = tick & full;
      end else begin : g_count
         localparam logic [CNT_W-1:0] SAT = CNT_W'(RUN_LIMIT + 1);
         localparam logic [CNT_W-1:0] LIM = CNT_W'(RUN_LIMIT);
         logic [CNT_W-1:0] cnt_q;

         always_ff @(posedge clk) begin
            if (!rst_n)          cnt_q <= '0;
            else if (tick) begin
               if (!full)        cnt_q <= '0;
               else if (cnt_q != SAT) cnt_q <= cnt_q + 1'b1;
            end
         end

         assign cnt  = cnt_q;
         assign trip = tick & full & (cnt_q >= LIM);
      end
   endgenerate
endmodule

// File: rtl/ovr_flag_ctl.sv
module ovr_flag_ctl (
   input  logic clk,
   input  logic rst_n,
   input  logic sample_evt,
   input  logic thr_hit,
   input  logic run_hit,
   output logic flag
);
   logic win_q;   // a run trip occurred since the last sample strobe

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         flag  <= 1'b0;
         win_q <= 1'b0;
      end else begin
         if (thr_hit || run_hit)        flag <= 1'b1;
         else if (sample_evt && !win_q) flag <= 1'b0;

         if (sample_evt) win_q <= 1'b0;
         else if (run_hit) win_q <= 1'b1;
      end
   end
endmodule

// File: rtl/ovr_detect.sv
module ovr_detect #(
   parameter int          SAMP_W    = 24,
   parameter int          THR_W     = 16,
   parameter int          RUN_LIMIT = 4,
   parameter logic [15:0] THR_RST   = 16'hCCCC
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     cfg_we,
   input  logic [THR_W-1:0]         cfg_wdata,
   output logic [THR_W-1:0]         thr_rdata,
   input  logic                     stage_valid,
   input  logic signed [SAMP_W-1:0] stage_data,
   input  logic                     mod_tick,
   input  logic                     mod_full,
   output logic                     ovr_flag
);
   localparam int CNT_W = ovr_pkg::run_cnt_w(RUN_LIMIT);

   generate
      if (SAMP_W < 2)     begin : g_bad_samp  $error("SAMP_W must be at least 2");     end
      if (THR_W < 1 || THR_W > 16) begin : g_bad_thr $error("THR_W must be 1..16"); end
      if (RUN_LIMIT < 0)  begin : g_bad_run   $error("RUN_LIMIT must be non-negative"); end
   endgenerate

   logic             over;
   logic             thr_hit;
   logic             run_hit;
   logic [CNT_W-1:0] run_cnt;

   ovr_thr_reg #(.THR_W(THR_W), .RST_VAL(THR_RST)) u_thr (
      .clk(clk), .rst_n(rst_n), .we(cfg_we), .wdata(cfg_wdata), .q(thr_rdata)
   );

   ovr_mag_cmp #(.SAMP_W(SAMP_W), .THR_W(THR_W)) u_cmp (
      .sample(stage_data), .thr(thr_rdata), .over(over)
   );

   assign thr_hit = stage_valid & over;

   ovr_run_cnt #(.RUN_LIMIT(RUN_LIMIT), .CNT_W(CNT_W)) u_run (
      .clk(clk), .rst_n(rst_n), .tick(mod_tick), .full(mod_full),
      .cnt(run_cnt), .trip(run_hit)
   );

   ovr_flag_ctl u_flag (
      .clk(clk), .rst_n(rst_n), .sample_evt(stage_valid),
      .thr_hit(thr_hit), .run_hit(run_hit), .flag(ovr_flag)
   );
endmodule

// File: rtl/ovr_detect_chk.sv
module ovr_detect_chk #(
   parameter int THR_W     = 16,
   parameter int RUN_LIMIT = 4,
   parameter int CNT_W     = ovr_pkg::run_cnt_w(RUN_LIMIT)
) (
   input logic             clk,
   input logic             rst_n,
   input logic             cfg_we,
   input logic [THR_W-1:0] cfg_wdata,
   input logic [THR_W-1:0] thr_rdata,
   input logic             stage_valid,
   input logic             mod_tick,
   input logic             mod_full,
   input logic             thr_hit,
   input logic             run_hit,
   input logic [CNT_W-1:0] run_cnt,
   input logic             ovr_flag
);
   // R2
   thr_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_we |=> thr_rdata == $past(cfg_wdata));
   // R2
   thr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_we |=> $stable(thr_rdata));
   // R3
   thr_trip_chk: assert property (@(posedge clk) disable iff (!rst_n)
      thr_hit |=> ovr_flag);
   // R6
   run_trip_chk: assert property (@(posedge clk) disable iff (!rst_n)
      run_hit |=> ovr_flag);
   // R7
   run_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mod_tick && !mod_full) |=> run_cnt == '0);
   // R10
   run_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
      run_cnt <= CNT_W'(RUN_LIMIT + 1));
   // R9
   flag_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ovr_flag) |-> $past(thr_hit || run_hit));
   // R8
   flag_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ovr_flag) |-> $past(stage_valid));
endmodule

bind ovr_detect ovr_detect_chk #(.THR_W(THR_W), .RUN_LIMIT(RUN_LIMIT), .CNT_W(CNT_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
   .thr_rdata(thr_rdata), .stage_valid(stage_valid), .mod_tick(mod_tick),
   .mod_full(mod_full), .thr_hit(thr_hit), .run_hit(run_hit),
   .run_cnt(run_cnt), .ovr_flag(ovr_flag)
);

// File: tb/sim_ovr_detect.sv
module sim_ovr_detect;
   logic               clk = 1'b0;
   logic               rst_n = 1'b0;
   logic               cfg_we = 1'b0;
   logic [15:0]        cfg_wdata = '0;
   logic [15:0]        thr_rdata;
   logic               stage_valid = 1'b0;
   logic signed [23:0] stage_data = '0;
   logic               mod_tick = 1'b0;
   logic               mod_full = 1'b0;
   logic               ovr_flag;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   // reference state, built from the requirements
   logic [15:0] m_thr = 16'hCCCC;
   int          m_cnt = 0;
   bit          m_win = 1'b0;
   bit          m_flag = 1'b0;

   always #4 clk = ~clk;   // 125 MHz

   ovr_detect u0 (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
      .thr_rdata(thr_rdata), .stage_valid(stage_valid), .stage_data(stage_data),
      .mod_tick(mod_tick), .mod_full(mod_full), .ovr_flag(ovr_flag)
   );

   function automatic bit over_thr(input logic signed [23:0] x, input logic [15:0] t);
      longint mag = (x < 0) ? -longint'(x) : longint'(x);
      return (mag << 16) > (longint'(t) << 23);
   endfunction

   task automatic check(input string req, input longint act, input longint exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
      end
   endtask

   // apply one cycle of inputs, advance the model at the edge, settle
   task automatic cyc(input bit sv, input int sd, input bit mt, input bit mf,
                      input bit we = 1'b0, input int wd = 0);
      bit thr_hit, run_hit;
      @(negedge clk);
      stage_valid = sv; stage_data = 24'(sd);
      mod_tick = mt; mod_full = mf;
      cfg_we = we; cfg_wdata = 16'(wd);
      @(posedge clk);
      if (rst_n) begin
         thr_hit = sv && over_thr(24'(sd), m_thr);
         run_hit = mt && mf && (m_cnt >= 4);
         if (thr_hit || run_hit) m_flag = 1'b1;
         else if (sv && !m_win)  m_flag = 1'b0;
         if (sv) m_win = 1'b0; else if (run_hit) m_win = 1'b1;
         if (mt) m_cnt = mf ? ((m_cnt < 5) ? m_cnt + 1 : 5) : 0;
         if (we) m_thr = 16'(wd);
      end
      #1;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) cyc(0, 0, 0, 0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog expired");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'h0C0FFEE5));
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;
      #1;
      check("R1 threshold", thr_rdata, 16'hCCCC);
      check("R1 flag", ovr_flag, 0);

      // 0xCCCC * 2^7 = 6710784 is the exact boundary for 24-bit samples
      cyc(1, 6710784, 0, 0);  check("R4 equal", ovr_flag, 0);
      cyc(1, 6710785, 0, 0);  check("R3 above", ovr_flag, 1);
      idle(3);                check("R9 hold", ovr_flag, 1);
      cyc(1, 0, 0, 0);        check("R8 clear", ovr_flag, 0);
      cyc(1, -6710784, 0, 0); check("R5 neg equal", ovr_flag, 0);
      cyc(1, -6710785, 0, 0); check("R5 neg above", ovr_flag, 1);
      cyc(1, -8388608, 0, 0); check("R5 most negative", ovr_flag, 1);
      cyc(1, 100, 0, 0);      check("R8 clear after neg", ovr_flag, 0);

      cyc(0, 0, 0, 0, 1, 16'h4000);
      check("R2 readback", thr_rdata, 16'h4000);
      cyc(1, 2097152, 0, 0);  check("R2 new boundary", ovr_flag, 0);
      cyc(1, 2097153, 0, 0);  check("R2 new above", ovr_flag, 1);
      cyc(1, 2097152, 0, 0);  check("R8 boundary clears", ovr_flag, 0);
      cyc(0, 0, 0, 0, 1, 16'hCCCC);

      for (int i = 0; i < 4; i++) cyc(0, 0, 1, 1);
      check("R6 four ticks", ovr_flag, 0);
      cyc(0, 0, 1, 1);        check("R6 fifth tick", ovr_flag, 1);
      cyc(0, 0, 1, 0);
      cyc(1, 0, 0, 0);        check("R9 run in window keeps", ovr_flag, 1);
      cyc(1, 0, 0, 0);        check("R8 run clear", ovr_flag, 0);

      for (int i = 0; i < 4; i++) cyc(0, 0, 1, 1);
      cyc(0, 0, 1, 0);
      cyc(0, 0, 1, 1);        check("R7 broken run", ovr_flag, 0);
      cyc(0, 0, 1, 0);
      for (int i = 0; i < 3; i++) cyc(0, 0, 1, 1);
      idle(4);
      cyc(0, 0, 0, 1);
      cyc(0, 0, 1, 1);        check("R7 gap no trip yet", ovr_flag, 0);
      cyc(0, 0, 1, 1);        check("R7 gap keeps run", ovr_flag, 1);
      cyc(0, 0, 1, 0); cyc(1, 0, 0, 0); cyc(1, 0, 0, 0);
      check("R8 clear after gap run", ovr_flag, 0);

      for (int i = 0; i < 50; i++) cyc(0, 0, 1, 1);
      check("R10 long run", ovr_flag, 1);
      cyc(1, 0, 0, 0);        check("R10 still tripping", ovr_flag, 1);
      cyc(0, 0, 1, 0); cyc(1, 0, 0, 0); cyc(1, 0, 0, 0);
      check("R10 cleared", ovr_flag, 0);
      for (int i = 0; i < 4; i++) cyc(0, 0, 1, 1);
      check("R10 restart four", ovr_flag, 0);
      cyc(0, 0, 1, 1);        check("R10 restart fifth", ovr_flag, 1);

      for (int i = 0; i < 4000; i++) begin
         bit sv = ($urandom % 6) == 0;
         bit mt = ($urandom % 2) == 0;
         bit mf = ($urandom % 8) != 0;
         bit we = ($urandom % 400) == 0;
         int base = 6710784 - 2000 + int'($urandom % 4000);
         int sd = (($urandom % 2) == 0) ? base : -base;
         if (($urandom % 3) == 0) sd = int'($urandom % 4000000);
         cyc(sv, sd, mt, mf, we, we ? int'(16'hC000 + ($urandom % 16'h1000)) : 0);
         check("R3/R6/R8 random flag", ovr_flag, m_flag);
         check("R2 random threshold", thr_rdata, m_thr);
      end

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule